// File: doc/BRIEF.md
# Cache Buffer Garbage Collection Sequencer

This block reclaims a single caching buffer of a flash disk cache once the buffer's overflow block has no free page left. When it is triggered, it captures the page-state maps of the buffer's old primary and overflow blocks, the home page of every overflow page, and the disk power state. It then asks for a fresh primary block and walks the old pages in an order that rebuilds least-recently-used recency. The overflow block is walked first, from its last-written page back to its first. The primary block follows, from its lowest page upward.

For each walked page the block issues one command over a valid/ready handshake, or it skips the page. A copy command moves a surviving page into the new primary block at its home slot. If that slot is already taken, the copy goes to the next sequential page of a new overflow block, which is requested only at the first such collision. A flush command writes a dirty page back to the disk, and this is chosen only while the disk is spinning. When the disk is spun down, dirty pages are kept by copying them instead. At the end, both old blocks are queued for erase and a one-cycle done pulse closes the job. Flash timing and the disk path lie outside the block, behind the handshakes.

Top module: `gc_sequencer`

## Requirements
- R1: After reset, busy, done, cmd_valid and blk_req are low. A gc_start seen while idle begins a job, and busy is high from the next cycle until the cycle done is high.
- R2: A job first raises blk_req for the new primary block and holds it, with cmd_valid low, until blk_gnt. The granted blk_id becomes the new primary block.
- R3: Pages are visited in this order: old overflow pages NPB-1 down to 0, then old primary pages 0 up to NPB-1. Commands leave in that order.
- R4: A page whose 2-bit state is 0 (free) or 1 (invalid) gets no command.
- R5: A clean page (state 2) gets a copy command (cmd_op 1), with cmd_src_blk/cmd_src_pg naming the old page. If its home slot in the new primary is still empty, the destination is the new primary at the home slot. The home slot of a primary page is its own index; that of an overflow page is its ovf_home field (bits IDX_W*j upward).
- R6: A dirty page (state 3) is copied like a clean page when disk_down was high at the trigger. Otherwise it gets a flush command (cmd_op 2) with both destination fields 0.
- R7: A copy whose home slot is already taken goes to a new overflow block. That block is requested through blk_req/blk_gnt only at the first such copy of the job, and it is filled from page 0 upward.
- R8: After the walk, the block issues erase commands (cmd_op 3, page and destination fields 0): first for the old primary block, then for the old overflow block.
- R9: done is high for exactly one cycle, the cycle after the second erase command is accepted. busy is low in that cycle.
- R10: While cmd_valid is high and cmd_ready is low, every command field holds its value.
- R11: gc_start while busy is ignored. Inputs changing after the trigger do not alter the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gc_start | input | 1 | Trigger: overflow block of the buffer is full |
| old_pri_blk | input | BLK_W | Old primary block number |
| old_ovf_blk | input | BLK_W | Old overflow block number |
| pri_state | input | 2*NPB | Page states of old primary, 2 bits per page |
| ovf_state | input | 2*NPB | Page states of old overflow, 2 bits per page |
| ovf_home | input | IDX_W*NPB | Home page index of every overflow page |
| disk_down | input | 1 | Disk is spun down or idle |
| blk_req | output | 1 | Request for a free block |
| blk_gnt | input | 1 | Free block granted this cycle |
| blk_id | input | BLK_W | Granted block number |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_op | output | 2 | 1 copy, 2 flush, 3 erase |
| cmd_src_blk | output | BLK_W | Source block of the command |
| cmd_src_pg | output | IDX_W | Source page of the command |
| cmd_dst_blk | output | BLK_W | Destination block of a copy |
| cmd_dst_pg | output | IDX_W | Destination page of a copy |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The first collision of a job can meet the block-request handshake: the copy that needs the new overflow block must wait for a grant, and its destination must name the block granted in that same stall. The bench provokes this with random page maps that force home-slot collisions, under both zero-wait and randomly delayed grants and ready signals. It judges every accepted command against a model of the walk computed from the requirements. A second overlap is a trigger that lands during a running job. Some runs pulse gc_start mid-job and scramble the inputs; these are judged by an unchanged command stream and a single done pulse.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_COPY  = 2'd1,
      OP_FLUSH = 2'd2,
      OP_ERASE = 2'd3
   } gc_op_e;

   typedef enum logic [1:0] {
      PG_FREE  = 2'd0,
      PG_STALE = 2'd1,
      PG_CLEAN = 2'd2,
      PG_DIRTY = 2'd3
   } pg_state_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_GNT_P,
      S_SCAN,
      S_GNT_O,
      S_ISSUE,
      S_ERS_P,
      S_ERS_O
   } gc_state_e;
endpackage

// File: rtl/gcs_classify.sv
module gcs_classify
   import gcs_pkg::*;
(
   input  logic [1:0] page_st,
   input  logic       spun_down,
   output gc_op_e     act
);
   always_comb begin
      unique case (pg_state_e'(page_st))
         PG_CLEAN: act = OP_COPY;
         PG_DIRTY: act = spun_down ? OP_COPY : OP_FLUSH;
         default:  act = OP_NONE;
      endcase
   end
endmodule

// File: rtl/gcs_slots.sv
module gcs_slots #(
   parameter int NPB   = 8,
   parameter int IDX_W = $clog2(NPB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             commit,
   input  logic [IDX_W-1:0] home,
   output logic             occ_hit,
   output logic [IDX_W-1:0] ovf_ptr
);
   logic [NPB-1:0]   occ_q;
   logic [IDX_W-1:0] ptr_q;

   assign occ_hit = occ_q[home];
   assign ovf_ptr = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         occ_q <= '0;
         ptr_q <= '0;
      end else if (commit) begin
         if (occ_q[home]) ptr_q <= ptr_q + 1'b1;
         else             occ_q[home] <= 1'b1;
      end
   end
endmodule

// File: rtl/gc_sequencer.sv
module gc_sequencer
   import gcs_pkg::*;
#(
   parameter int NPB   = 8,
   parameter int BLK_W = 12,
   parameter int IDX_W = $clog2(NPB)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 gc_start,
   input  logic [BLK_W-1:0]     old_pri_blk,
   input  logic [BLK_W-1:0]     old_ovf_blk,
   input  logic [2*NPB-1:0]     pri_state,
   input  logic [2*NPB-1:0]     ovf_state,
   input  logic [IDX_W*NPB-1:0] ovf_home,
   input  logic                 disk_down,
   output logic                 blk_req,
   input  logic                 blk_gnt,
   input  logic [BLK_W-1:0]     blk_id,
   output logic                 cmd_valid,
   input  logic                 cmd_ready,
   output logic [1:0]           cmd_op,
   output logic [BLK_W-1:0]     cmd_src_blk,
   output logic [IDX_W-1:0]     cmd_src_pg,
   output logic [BLK_W-1:0]     cmd_dst_blk,
   output logic [IDX_W-1:0]     cmd_dst_pg,
   output logic                 busy,
   output logic                 done
);
   localparam int POS_W = IDX_W + 1;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(2*NPB-1);

   generate
      if (NPB < 2 || (NPB & (NPB-1)) != 0) begin : g_bad_npb
         $error("gc_sequencer: NPB must be a power of two, at least 2");
      end
      if (IDX_W != $clog2(NPB)) begin : g_bad_idx
         $error("gc_sequencer: IDX_W must equal clog2(NPB)");
      end
      if (BLK_W < 1) begin : g_bad_blk
         $error("gc_sequencer: BLK_W must be positive");
      end
   endgenerate

   gc_state_e              state_q;
   logic [POS_W-1:0]       pos_q;
   logic [2*NPB-1:0]       pri_q, ovf_q;
   logic [IDX_W*NPB-1:0]   home_q;
   logic [BLK_W-1:0]       opri_q, oovf_q, npri_q, novf_q;
   logic                   down_q, has_ovf_q, done_q;

   // per-page action decode
   gc_op_e act_pri [NPB];
   gc_op_e act_ovf [NPB];
   for (genvar i = 0; i < NPB; i++) begin : g_page
      gcs_classify u_cls_pri (
         .page_st   (pri_q[2*i +: 2]),
         .spun_down (down_q),
         .act       (act_pri[i])
      );
      gcs_classify u_cls_ovf (
         .page_st   (ovf_q[2*i +: 2]),
         .spun_down (down_q),
         .act       (act_ovf[i])
      );
   end

   // walk order: overflow newest-first, then primary lowest-first
   logic             from_ovf;
   logic [IDX_W-1:0] cur_pg, cur_home, ovf_ptr;
   gc_op_e           cur_act;
   logic             occ_hit, need_ovf, clr_slots, commit;

   assign from_ovf = ~pos_q[POS_W-1];
   assign cur_pg   = from_ovf ? ~pos_q[IDX_W-1:0] : pos_q[IDX_W-1:0];
   assign cur_act  = from_ovf ? act_ovf[cur_pg] : act_pri[cur_pg];
   assign cur_home = from_ovf ? home_q[IDX_W*cur_pg +: IDX_W] : cur_pg;
   assign need_ovf = (cur_act == OP_COPY) && occ_hit;

   assign clr_slots = (state_q == S_IDLE) && gc_start;
   assign commit    = (state_q == S_ISSUE) && cmd_ready && (cur_act == OP_COPY);

   gcs_slots #(.NPB(NPB), .IDX_W(IDX_W)) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_slots),
      .commit  (commit),
      .home    (cur_home),
      .occ_hit (occ_hit),
      .ovf_ptr (ovf_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         pos_q     <= '0;
         pri_q     <= '0;
         ovf_q     <= '0;
         home_q    <= '0;
         opri_q    <= '0;
         oovf_q    <= '0;
         npri_q    <= '0;
         novf_q    <= '0;
         down_q    <= 1'b0;
         has_ovf_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: if (gc_start) begin
               pri_q     <= pri_state;
               ovf_q     <= ovf_state;
               home_q    <= ovf_home;
               opri_q    <= old_pri_blk;
               oovf_q    <= old_ovf_blk;
               down_q    <= disk_down;
               pos_q     <= '0;
               has_ovf_q <= 1'b0;
               state_q   <= S_GNT_P;
            end
            S_GNT_P: if (blk_gnt) begin
               npri_q  <= blk_id;
               state_q <= S_SCAN;
            end
            S_SCAN: begin
               if (cur_act == OP_NONE) begin
                  if (pos_q == LAST_POS) state_q <= S_ERS_P;
                  else                   pos_q   <= pos_q + 1'b1;
               end else if (need_ovf && !has_ovf_q) begin
                  state_q <= S_GNT_O;
               end else begin
                  state_q <= S_ISSUE;
               end
            end
            S_GNT_O: if (blk_gnt) begin
               novf_q    <= blk_id;
               has_ovf_q <= 1'b1;
               state_q   <= S_ISSUE;
            end
            S_ISSUE: if (cmd_ready) begin
               if (pos_q == LAST_POS) state_q <= S_ERS_P;
               else begin
                  pos_q   <= pos_q + 1'b1;
                  state_q <= S_SCAN;
               end
            end
            S_ERS_P: if (cmd_ready) state_q <= S_ERS_O;
            S_ERS_O: if (cmd_ready) begin
               state_q <= S_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_valid   = 1'b0;
      cmd_op      = OP_NONE;
      cmd_src_blk = '0;
      cmd_src_pg  = '0;
      cmd_dst_blk = '0;
      cmd_dst_pg  = '0;
      unique case (state_q)
         S_ISSUE: begin
            cmd_valid   = 1'b1;
            cmd_op      = cur_act;
            cmd_src_blk = from_ovf ? oovf_q : opri_q;
            cmd_src_pg  = cur_pg;
            if (cur_act == OP_COPY) begin
               cmd_dst_blk = occ_hit ? novf_q  : npri_q;
               cmd_dst_pg  = occ_hit ? ovf_ptr : cur_home;
            end
         end
         S_ERS_P: begin
            cmd_valid   = 1'b1;
            cmd_op      = OP_ERASE;
            cmd_src_blk = opri_q;
         end
         S_ERS_O: begin
            cmd_valid   = 1'b1;
            cmd_op      = OP_ERASE;
            cmd_src_blk = oovf_q;
         end
         default: ;
      endcase
   end

   assign blk_req = (state_q == S_GNT_P) || (state_q == S_GNT_O);
   assign busy    = (state_q != S_IDLE);
   assign done    = done_q;
endmodule

// File: rtl/gc_sequencer_chk.sv
module gc_sequencer_chk #(
   parameter int BLK_W = 12,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gc_start,
   input logic             disk_down,
   input logic             blk_req,
   input logic             blk_gnt,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [1:0]       cmd_op,
   input logic [BLK_W-1:0] cmd_src_blk,
   input logic [IDX_W-1:0] cmd_src_pg,
   input logic [BLK_W-1:0] cmd_dst_blk,
   input logic [IDX_W-1:0] cmd_dst_pg,
   input logic             busy,
   input logic             done
);
   logic down_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)                down_seen <= 1'b0;
      else if (gc_start && !busy) down_seen <= disk_down;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!cmd_valid && !blk_req)); // R1
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_req && !blk_gnt) |=> blk_req); // R2
   AST_REQ_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_req |-> !cmd_valid); // R2
   AST_FLUSH_SPIN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd2) |-> !down_seen); // R6
   AST_ERASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd3)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)
         && $stable(cmd_src_blk) && $stable(cmd_src_pg)
         && $stable(cmd_dst_blk) && $stable(cmd_dst_pg))); // R10
endmodule

bind gc_sequencer gc_sequencer_chk #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gc_start    (gc_start),
   .disk_down   (disk_down),
   .blk_req     (blk_req),
   .blk_gnt     (blk_gnt),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_op      (cmd_op),
   .cmd_src_blk (cmd_src_blk),
   .cmd_src_pg  (cmd_src_pg),
   .cmd_dst_blk (cmd_dst_blk),
   .cmd_dst_pg  (cmd_dst_pg),
   .busy        (busy),
   .done        (done)
);

// File: tb/tb_gc_sequencer.sv
`timescale 1ns/1ps
module tb_gc_sequencer;
   localparam int NPB   = 4;
   localparam int BLK_W = 8;
   localparam int IDX_W = 2;
   localparam int MAXC  = 2*NPB + 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                 rst_n, gc_start, disk_down, blk_gnt, cmd_ready;
   logic [BLK_W-1:0]     old_pri_blk, old_ovf_blk, blk_id;
   logic [2*NPB-1:0]     pri_state, ovf_state;
   logic [IDX_W*NPB-1:0] ovf_home;
   logic                 blk_req, cmd_valid, busy, done;
   logic [1:0]           cmd_op;
   logic [BLK_W-1:0]     cmd_src_blk, cmd_dst_blk;
   logic [IDX_W-1:0]     cmd_src_pg, cmd_dst_pg;

   gc_sequencer #(.NPB(NPB), .BLK_W(BLK_W), .IDX_W(IDX_W)) dut (.*);

   int checks = 0, fails = 0, cycles = 0;
   logic [31:0] seed = 32'h1234_5678;

   int  e_op [MAXC], e_sb [MAXC], e_sp [MAXC], e_db [MAXC], e_dp [MAXC];
   string e_tag [MAXC];
   int  n_exp, e_grants;

   function automatic logic [31:0] rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // expected command list, built from the requirements
   task automatic model(input int opri, input int oovf, input int base,
                        input logic [2*NPB-1:0] ps, input logic [2*NPB-1:0] os,
                        input logic [IDX_W*NPB-1:0] hm, input bit dn);
      bit occ [NPB];
      bit hv = 0;
      int optr = 0;
      n_exp = 0;
      for (int i = 0; i < NPB; i++) occ[i] = 0;
      for (int p = 0; p < 2*NPB; p++) begin
         int pg, st, home, sb;
         if (p < NPB) begin
            pg = NPB-1-p; st = int'(os[2*pg +: 2]);
            home = int'(hm[IDX_W*pg +: IDX_W]); sb = oovf;
         end else begin
            pg = p-NPB; st = int'(ps[2*pg +: 2]); home = pg; sb = opri;
         end
         if (st < 2) continue;                       // R4 skip
         e_sb[n_exp] = sb; e_sp[n_exp] = pg;
         if (st == 3 && !dn) begin                   // R6 flush
            e_op[n_exp] = 2; e_db[n_exp] = 0; e_dp[n_exp] = 0; e_tag[n_exp] = "R6";
         end else begin
            e_op[n_exp] = 1;
            if (occ[home]) begin                     // R7 collision
               hv = 1; e_db[n_exp] = base+1; e_dp[n_exp] = optr; optr++;
               e_tag[n_exp] = "R7";
            end else begin                           // R5
               occ[home] = 1; e_db[n_exp] = base; e_dp[n_exp] = home;
               e_tag[n_exp] = (st == 3) ? "R6" : "R5";
            end
         end
         n_exp++;
      end
      e_op[n_exp] = 3; e_sb[n_exp] = opri; e_sp[n_exp] = 0; e_db[n_exp] = 0;
      e_dp[n_exp] = 0; e_tag[n_exp] = "R8"; n_exp++;
      e_op[n_exp] = 3; e_sb[n_exp] = oovf; e_sp[n_exp] = 0; e_db[n_exp] = 0;
      e_dp[n_exp] = 0; e_tag[n_exp] = "R8"; n_exp++;
      e_grants = hv ? 2 : 1;
   endtask

   task automatic run(input int run_no, input logic [2*NPB-1:0] ps,
                      input logic [2*NPB-1:0] os, input logic [IDX_W*NPB-1:0] hm,
                      input bit dn, input bit fast, input bit poke);
      int base = 16 + 3*(run_no % 60);
      int opri = run_no % 7, oovf = 8 + run_no % 5;
      int k = 0, g = 0, dones = 0, loop = 0;
      bit expect_done = 0, pend = 0;
      int p_op, p_sb, p_sp, p_db, p_dp;
      model(opri, oovf, base, ps, os, hm, dn);
      @(negedge clk);
      gc_start = 1; pri_state = ps; ovf_state = os; ovf_home = hm; disk_down = dn;
      old_pri_blk = BLK_W'(opri); old_ovf_blk = BLK_W'(oovf);
      @(negedge clk);
      gc_start = 0;
      chk(busy == 1'b1, "R1 busy after trigger", int'(busy), 1);
      pri_state = ~ps; ovf_state = ~os; ovf_home = ~hm; disk_down = ~dn;
      old_pri_blk = 8'hEE; old_ovf_blk = 8'hEF;
      while (dones == 0 && loop < 400) begin
         gc_start = (poke && loop == 3) ? 1'b1 : 1'b0;
         if (pend) begin
            chk(cmd_valid && int'(cmd_op) == p_op && int'(cmd_src_blk) == p_sb &&
                int'(cmd_src_pg) == p_sp && int'(cmd_dst_blk) == p_db &&
                int'(cmd_dst_pg) == p_dp, "R10 held command", int'(cmd_op), p_op);
         end
         if (cmd_valid && blk_req) chk(0, "R2 command during request", 1, 0);
         if (expect_done) begin
            chk(done && !busy, "R9 done after last erase", int'(done), 1);
            dones++;
         end else if (done) begin
            chk(0, "R9 early done", 1, 0);
            dones++;
         end
         blk_gnt = 0;
         if (blk_req) begin
            blk_gnt = fast || (rnd() % 3 == 0);
            if (blk_gnt) begin blk_id = BLK_W'(base + g); g++; end
         end
         cmd_ready = 0; pend = 0;
         if (cmd_valid) begin
            cmd_ready = fast || (rnd() % 3 != 0);
            if (cmd_ready) begin
               if (k < n_exp) begin
                  chk(int'(cmd_op) == e_op[k] && int'(cmd_src_blk) == e_sb[k] &&
                      int'(cmd_src_pg) == e_sp[k] && int'(cmd_dst_blk) == e_db[k] &&
                      int'(cmd_dst_pg) == e_dp[k],
                      $sformatf("%s R3 cmd %0d op/sb/sp/db/dp %0d/%0d/%0d/%0d/%0d vs",
                         e_tag[k], k, cmd_op, cmd_src_blk, cmd_src_pg, cmd_dst_blk,
                         cmd_dst_pg),
                      e_op[k]*10000 + e_sb[k]*100 + e_sp[k], e_db[k]*100 + e_dp[k]);
                  if (k == n_exp-1) expect_done = 1;
               end else chk(0, "R4 extra command", k, n_exp);
               k++;
            end else begin
               pend = 1; p_op = int'(cmd_op); p_sb = int'(cmd_src_blk);
               p_sp = int'(cmd_src_pg); p_db = int'(cmd_dst_blk); p_dp = int'(cmd_dst_pg);
            end
         end
         @(negedge clk);
         loop++; cycles++;
      end
      gc_start = 0; blk_gnt = 0; cmd_ready = 0;
      if (loop >= 400) chk(0, "watchdog expired", loop, 400);
      chk(k == n_exp, poke ? "R11 command count" : "R4 command count", k, n_exp);
      chk(g == e_grants, "R7 grant count", g, e_grants);
      chk(!done && !busy, "R9 done one cycle", int'(done), 0);
   endtask

   initial begin
      rst_n = 0; gc_start = 0; disk_down = 0; blk_gnt = 0; cmd_ready = 0;
      old_pri_blk = '0; old_ovf_blk = '0; blk_id = '0;
      pri_state = '0; ovf_state = '0; ovf_home = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !cmd_valid && !blk_req, "R1 reset state",
          int'({busy, done, cmd_valid, blk_req}), 0);
      // directed: all slots collide, disk down (R7), then all skipped (R4)
      run(0, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0);
      run(1, 8'h55, 8'h00, 8'h1B, 1'b0, 1'b0, 1'b0);
      run(2, 8'hFF, 8'hFF, 8'h1B, 1'b0, 1'b0, 1'b1);
      for (int r = 3; r < 400; r++) begin
         logic [31:0] a = rnd();
         run(r, a[7:0], a[15:8], a[23:16], a[24], (r % 3 == 0), (r % 5 == 0));
         if (cycles > 150000) begin
            chk(0, "watchdog expired", cycles, 150000);
            break;
         end
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule